// File: doc/BRIEF.md
# Two-Level Pointer Address Generator

This block produces the effective address for a doubly indirect, doubly indexed operand in a small 8-bit processor core that has optionally widened index registers. A zero-page operand byte selects a 16-bit pointer in page zero. That pointer, plus a contribution from the X register, locates a second 16-bit pointer. The second pointer plus the Y register gives the final address. The block does the four byte reads itself, one at a time, over a synchronous byte-wide read port, and then pulses `done` with the address.

The X contribution depends on the width of X. When X is a narrow (8-bit) index it selects an entry in a table of 2-byte pointers, so it is doubled. When X is a full 16-bit register it acts as a base and is added unscaled. Y is zero-extended when narrow and added in full when wide. All sums wrap modulo 2^16. Instruction decode, the final data access and register writeback belong to the surrounding core.

Top module: `nested_ptr_agu`

## Requirements
- R1: During and straight after reset, `busy`, `done` and `rd_en` are 0 and `eff_addr` is 0.
- R2: The first two reads go to page zero, at `{8'h00, zp}` and then `{8'h00, zp+1}`, where the low byte wraps within the page (operand 0xFF reads its high byte from 0x0000).
- R3: Pointers are little-endian. The byte read from the lower address is bits 7:0 and the next byte is bits 15:8.
- R4: With `x_wide`=0, the third read address is pointer1 + 2*`x_val[7:0]` mod 2^16. `x_val[15:8]` has no effect.
- R5: With `x_wide`=1, the third read address is pointer1 + `x_val` mod 2^16, without scaling.
- R6: The fourth read address is the third read address + 1 mod 2^16, so 0xFFFF is followed by 0x0000.
- R7: `eff_addr` = pointer2 + Y mod 2^16. Y is `{8'h00, y_val[7:0]}` when `y_wide`=0 (the upper bits have no effect) and `y_val` when `y_wide`=1.
- R8: If `start` is high while idle, the operands are taken at that clock edge. `busy` and the first read strobe rise at that same edge. `done` is a one-cycle pulse that rises on the sixth following edge, at which point `busy` falls and `eff_addr` takes its new value.
- R9: While `busy` is high, `start` and any change to `zp`, `x_val`, `y_val`, `x_wide` or `y_wide` have no effect on the running sequence or its result.
- R10: Each operation issues exactly four read strobes, in the order pointer1 low, pointer1 high, pointer2 low, pointer2 high. `rd_en` is never high while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address computation (taken only while idle) |
| zp | input | 8 | Zero-page operand byte |
| x_val | input | 16 | X register value |
| x_wide | input | 1 | 1: X is 16 bits wide, 0: X is 8 bits wide |
| y_val | input | 16 | Y register value |
| y_wide | input | 1 | 1: Y is 16 bits wide, 0: Y is 8 bits wide |
| rd_en | output | 1 | Read strobe to byte memory |
| rd_addr | output | 16 | Read address |
| rd_data | input | 8 | Read data, valid one cycle after the strobe |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: `eff_addr` is valid |
| eff_addr | output | 16 | Final effective address |

## Verification
The bench builds the block with its default parameters: 8-bit data and zero-page operand, which gives a 16-bit address space. With these values every wrap point can be reached by directed operands. These are the page-zero wrap at operand 0xFF, the second-pointer fetch that straddles 0xFFFF, and a final Y sum that overflows past 0xFFFF. The bench also sends random operands that cover all four combinations of X and Y width, with upper index bits set that must be ignored.

// File: rtl/nested_agu_pkg.sv
package nested_agu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_P1H,
    ST_CAP_P1L,
    ST_CAP_P1H,
    ST_REQ_P2H,
    ST_CAP_P2L,
    ST_CAP_P2H
  } agu_state_t;

endpackage

// File: rtl/agu_index_ext.sv
// Converts an index register value into an address offset.
// Narrow indices are zero-extended and optionally shifted left.
module agu_index_ext #(
  parameter int AW          = 16,
  parameter int NW          = 8,
  parameter int SHORT_SHIFT = 0
) (
  input  logic [AW-1:0] idx,
  input  logic          wide,
  output logic [AW-1:0] ofs
);

  localparam int PAD = AW - NW;

  logic [AW-1:0] narrow_ext;
  logic [AW-1:0] narrow_ofs;

  assign narrow_ext = {{PAD{1'b0}}, idx[NW-1:0]};

  generate
    if (SHORT_SHIFT == 0) begin : g_plain
      assign narrow_ofs = narrow_ext;
    end else begin : g_scaled
      assign narrow_ofs = narrow_ext << SHORT_SHIFT;
    end
  endgenerate

  always_comb begin
    ofs = wide ? idx : narrow_ofs;
  end

endmodule

// File: rtl/agu_seq.sv
// Read sequencer: two pointer fetches over a synchronous byte port.
module agu_seq
  import nested_agu_pkg::*;
#(
  parameter int DW = 8,
  parameter int ZW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [ZW-1:0]   zp,
  input  logic [2*DW-1:0] x_ofs,
  input  logic [2*DW-1:0] y_ofs,
  input  logic [DW-1:0]   rd_data,
  output logic            accept,
  output logic            rd_en,
  output logic [2*DW-1:0] rd_addr,
  output logic            busy,
  output logic            done,
  output logic [2*DW-1:0] eff_addr
);

  localparam int AW = 2 * DW;
  localparam logic [ZW-1:0] ZP_ONE = {{(ZW-1){1'b0}}, 1'b1};
  localparam logic [AW-1:0] A_ONE  = {{(AW-1){1'b0}}, 1'b1};

  agu_state_t    st;
  logic [ZW-1:0] zp_q;
  logic [DW-1:0] lo_q;

  function automatic logic [AW-1:0] page0(input logic [ZW-1:0] off);
    return {{(AW-ZW){1'b0}}, off};
  endfunction

  assign accept = (st == ST_IDLE) && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      zp_q     <= '0;
      lo_q     <= '0;
      rd_en    <= 1'b0;
      rd_addr  <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      eff_addr <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            zp_q    <= zp;
            rd_addr <= page0(zp);
            rd_en   <= 1'b1;
            busy    <= 1'b1;
            st      <= ST_REQ_P1H;
          end
        end
        ST_REQ_P1H: begin
          rd_addr <= page0(zp_q + ZP_ONE);
          st      <= ST_CAP_P1L;
        end
        ST_CAP_P1L: begin
          lo_q  <= rd_data;
          rd_en <= 1'b0;
          st    <= ST_CAP_P1H;
        end
        ST_CAP_P1H: begin
          rd_addr <= {rd_data, lo_q} + x_ofs;
          rd_en   <= 1'b1;
          st      <= ST_REQ_P2H;
        end
        ST_REQ_P2H: begin
          rd_addr <= rd_addr + A_ONE;
          st      <= ST_CAP_P2L;
        end
        ST_CAP_P2L: begin
          lo_q  <= rd_data;
          rd_en <= 1'b0;
          st    <= ST_CAP_P2H;
        end
        ST_CAP_P2H: begin
          eff_addr <= {rd_data, lo_q} + y_ofs;
          done     <= 1'b1;
          busy     <= 1'b0;
          st       <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nested_ptr_agu.sv
// Effective address generator for the ((zp),X),Y operand form.
module nested_ptr_agu #(
  parameter int DW = 8,
  parameter int ZW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [ZW-1:0]   zp,
  input  logic [2*DW-1:0] x_val,
  input  logic            x_wide,
  input  logic [2*DW-1:0] y_val,
  input  logic            y_wide,
  output logic            rd_en,
  output logic [2*DW-1:0] rd_addr,
  input  logic [DW-1:0]   rd_data,
  output logic            busy,
  output logic            done,
  output logic [2*DW-1:0] eff_addr
);

  localparam int AW = 2 * DW;

  logic          accept;
  logic [AW-1:0] x_q, y_q;
  logic          xw_q, yw_q;
  logic [AW-1:0] x_ofs, y_ofs;

  // Index operands are captured once per operation.
  always_ff @(posedge clk) begin
    if (rst) begin
      x_q  <= '0;
      y_q  <= '0;
      xw_q <= 1'b0;
      yw_q <= 1'b0;
    end else if (accept) begin
      x_q  <= x_val;
      y_q  <= y_val;
      xw_q <= x_wide;
      yw_q <= y_wide;
    end
  end

  // A narrow X steps through a table of 2-byte pointers.
  agu_index_ext #(.AW(AW), .NW(DW), .SHORT_SHIFT(1)) i_x_ext (
    .idx  (x_q),
    .wide (xw_q),
    .ofs  (x_ofs)
  );

  agu_index_ext #(.AW(AW), .NW(DW), .SHORT_SHIFT(0)) i_y_ext (
    .idx  (y_q),
    .wide (yw_q),
    .ofs  (y_ofs)
  );

  agu_seq #(.DW(DW), .ZW(ZW)) i_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .zp       (zp),
    .x_ofs    (x_ofs),
    .y_ofs    (y_ofs),
    .rd_data  (rd_data),
    .accept   (accept),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .busy     (busy),
    .done     (done),
    .eff_addr (eff_addr)
  );

endmodule

// File: rtl/nested_ptr_agu_chk.sv
module nested_ptr_agu_chk #(
  parameter int DW = 8,
  parameter int ZW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            rd_en,
  input logic [2*DW-1:0] rd_addr,
  input logic [2*DW-1:0] eff_addr
);

  localparam int AW = 2 * DW;

  assert_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && rd_en));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_first_page0_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (rd_en && rd_addr[AW-1:ZW] == '0));

  assert_second_page0_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> (rd_en && rd_addr[AW-1:ZW] == '0 &&
                     rd_addr[ZW-1:0] == ZW'($past(rd_addr[ZW-1:0]) + 1'b1)));

  assert_no_read_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rd_en);

  assert_eff_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(eff_addr) |-> done);

endmodule

bind nested_ptr_agu nested_ptr_agu_chk #(.DW(DW), .ZW(ZW)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .eff_addr (eff_addr)
);

// File: tb/test_nested_ptr_agu.sv
module test_nested_ptr_agu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  zp = '0;
  logic [15:0] x_val = '0, y_val = '0;
  logic        x_wide = 1'b0, y_wide = 1'b0;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [7:0]  rd_data = '0;
  logic        busy, done;
  logic [15:0] eff_addr;

  always #10 clk = ~clk;

  nested_ptr_agu i_nested_ptr_agu (
    .clk(clk), .rst(rst), .start(start), .zp(zp),
    .x_val(x_val), .x_wide(x_wide), .y_val(y_val), .y_wide(y_wide),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .eff_addr(eff_addr)
  );

  int nchk = 0;
  int nerr = 0;

  typedef struct packed {
    logic [3:0][15:0] ra;
    logic [15:0]      eff;
    logic             xw;
  } exp_t;

  exp_t sb[$];

  logic [7:0] mem_ovr [int];

  function automatic logic [7:0] mb(input logic [15:0] a);
    if (mem_ovr.exists(int'(a))) return mem_ovr[int'(a)];
    return a[7:0] ^ (a[15:8] * 8'd29) ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (rd_en) rd_data <= mb(rd_addr);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke16(input logic [15:0] a, input logic [15:0] v);
    mem_ovr[int'(a)] = v[7:0];
    mem_ovr[int'(a + 16'd1)] = v[15:8];
  endtask

  // Monitor: compares reads, result and latency with the scoreboard.
  int cyc = 0;
  int t0 = 0;
  int nrd = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (start && !busy) begin
        t0 = cyc;
        nrd = 0;
      end
      if (rd_en) begin
        if (sb.size() == 0) chk(1'b0, "R9 R10 read with no operation", rd_addr, 0);
        else if (nrd > 3) chk(1'b0, "R10 extra read", nrd, 4);
        else begin
          case (nrd)
            0, 1: chk(rd_addr == sb[0].ra[nrd], "R2 page-zero read", rd_addr, sb[0].ra[nrd]);
            2: chk(rd_addr == sb[0].ra[2], sb[0].xw ? "R5 wide X read" : "R4 narrow X read",
                   rd_addr, sb[0].ra[2]);
            default: chk(rd_addr == sb[0].ra[3], "R6 second pointer high read", rd_addr, sb[0].ra[3]);
          endcase
        end
        nrd++;
      end
      if (done) begin
        if (sb.size() == 0) chk(1'b0, "R9 unexpected done", 1, 0);
        else begin
          chk(eff_addr == sb[0].eff, "R3 R7 effective address", eff_addr, sb[0].eff);
          chk(cyc - t0 == 7, "R8 latency", cyc - t0, 7);
          chk(nrd == 4, "R10 read count", nrd, 4);
          chk(!busy, "R8 busy low with done", busy, 0);
          void'(sb.pop_front());
        end
      end
    end
  end

  // Driver: computes the expected item, pushes it and starts the block.
  task automatic run_op(input logic [7:0] z, input logic [15:0] x, input logic xw,
                        input logic [15:0] y, input logic yw, input bit disturb);
    exp_t e;
    logic [15:0] p1, xo, a2, p2, yo;
    while (busy) begin @(posedge clk); #1; end
    p1 = {mb({8'h00, z + 8'd1}), mb({8'h00, z})};
    xo = xw ? x : {7'b0, x[7:0], 1'b0};
    a2 = p1 + xo;
    p2 = {mb(a2 + 16'd1), mb(a2)};
    yo = yw ? y : {8'h00, y[7:0]};
    e.ra[0] = {8'h00, z};
    e.ra[1] = {8'h00, z + 8'd1};
    e.ra[2] = a2;
    e.ra[3] = a2 + 16'd1;
    e.eff   = p2 + yo;
    e.xw    = xw;
    sb.push_back(e);
    zp = z; x_val = x; x_wide = xw; y_val = y; y_wide = yw;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (disturb) begin
      // R9: new operands and start pulses while busy must be ignored
      zp = ~z; x_val = ~x; x_wide = ~xw; y_val = ~y; y_wide = ~yw;
      start = 1'b1;
      repeat (3) begin @(posedge clk); #1; end
      start = 1'b0;
    end
    while (busy) begin @(posedge clk); #1; end
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(!busy && !done && !rd_en, "R1 outputs in reset", {busy, done, rd_en}, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !rd_en, "R1 outputs after reset", {busy, done, rd_en}, 0);
    chk(eff_addr == 16'h0000, "R1 eff_addr after reset", eff_addr, 0);
    @(posedge clk); #1;

    // R4 R3: narrow X doubled into a pointer table
    poke16(16'h0010, 16'h3000);
    poke16(16'h3006, 16'h4567);
    run_op(8'h10, 16'h0003, 1'b0, 16'h0005, 1'b0, 1'b0);
    // R2: operand 0xFF wraps to 0x00 for the high byte
    mem_ovr[32'h00FF] = 8'h34;
    mem_ovr[32'h0000] = 8'h12;
    run_op(8'hFF, 16'h0001, 1'b0, 16'h0010, 1'b0, 1'b0);
    // R4: upper bits of narrow X ignored
    run_op(8'h10, 16'hAB80, 1'b0, 16'h0000, 1'b0, 1'b0);
    // R5: wide X unscaled
    run_op(8'h10, 16'h1234, 1'b1, 16'h0001, 1'b0, 1'b0);
    // R6 R7: second pointer straddles 0xFFFF, wide Y wraps past 0xFFFF
    poke16(16'h0020, 16'hFFF1);
    mem_ovr[32'hFFFF] = 8'hF0;
    mem_ovr[32'h0000] = 8'hFF;
    run_op(8'h20, 16'h0007, 1'b0, 16'h0020, 1'b1, 1'b0);
    // R7: narrow Y ignores upper bits
    run_op(8'h20, 16'h0007, 1'b0, 16'hFF22, 1'b0, 1'b0);
    // R5 R7: wide X wraps, wide Y
    run_op(8'h40, 16'hFFFE, 1'b1, 16'hFFFF, 1'b1, 1'b0);
    // R9: disturbance while busy
    run_op(8'h10, 16'h0003, 1'b0, 16'h0005, 1'b0, 1'b1);
    run_op(8'hFF, 16'h8001, 1'b1, 16'h9000, 1'b1, 1'b1);

    for (int i = 0; i < 60; i++) begin
      run_op(8'($urandom), 16'($urandom), 1'($urandom), 16'($urandom), 1'($urandom), (i % 7) == 3);
    end

    repeat (10) @(posedge clk);
    chk(sb.size() == 0, "R8 R10 all operations completed", sb.size(), 0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule